// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block turns one block-transfer instruction into a series of single-word memory accesses. A start strobe presents the instruction's low 28 bits (the condition is assumed to be resolved upstream) together with the current value of the base register. The sequencer counts the selected registers and works out the lowest address the transfer touches. It then issues one access per selected register, from the lowest register index to the highest, with the address rising by four bytes on each beat.

Every beat holds its address and register index until the memory side accepts it with `ready_i`. After the last beat the block raises a one-cycle completion pulse. That pulse carries the new base value and a flag saying whether it should be written back. The register file, the data path and any status-register side effects stay outside the block. The load/store direction, the user-bank request and the base register number are only passed out for the surrounding logic to act on.

Top module: `mrt_seq`

## Requirements
- R1: Fields are decoded from `instr_i` as follows: bit 24 before/after, bit 23 up/down, bit 22 user bank, bit 21 write-back, bit 20 load, bits 19:16 base register number, bits 15:0 register list. A start is accepted only when bits 27:25 equal 3'b100. Any other value is ignored: no request, no error and no busy.
- R2: One beat is issued for each set bit of the register list and for no other index. Beats come in ascending register index order, so the number of beats equals the population count of the list.
- R3: With n set bits, the first beat's address depends on bits 24 and 23. For {24,23} = 01 it is the base. For 11 it is base+4. For 00 it is base-4n+4. For 10 it is base-4n.
- R4: Each beat after the first uses the previous beat's address plus 4, with modulo-2^32 wrap.
- R5: While `req_o` is high and `ready_i` is low, `addr_o` and `reg_idx_o` hold their values.
- R6: In the cycle after the last beat is accepted, `done_o` is high for exactly one cycle and `req_o` is low. During that cycle `wb_base_o` is base+4n when bit 23 is set and base-4n when it is clear, and `wb_en_o` equals bit 21.
- R7: An accepted start with an empty register list raises `err_o` for one cycle in the cycle after the start. It issues no beat and no completion pulse, and the block stays idle.
- R8: `load_o` (bit 20), `user_bank_o` (bit 22) and `base_reg_o` (bits 19:16) keep the values captured at start for the whole operation.
- R9: A start strobe seen while the block is busy is ignored. The running operation continues unchanged and no second operation follows it.
- R10: During and right after reset, `busy_o`, `req_o`, `done_o`, `err_o` and `wb_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled only while idle |
| instr_i | input | 28 | Instruction bits 27:0 |
| base_i | input | 32 | Base register value at start |
| busy_o | output | 1 | An operation is in progress |
| req_o | output | 1 | Memory beat request |
| ready_i | input | 1 | Memory accepts the current beat |
| addr_o | output | 32 | Byte address of the current beat |
| reg_idx_o | output | 4 | Register index of the current beat |
| load_o | output | 1 | 1 for a load, 0 for a store |
| user_bank_o | output | 1 | User register bank / status load requested |
| base_reg_o | output | 4 | Base register number |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Write the new base back (valid with done_o) |
| wb_base_o | output | 32 | New base value (valid with done_o) |
| err_o | output | 1 | One-cycle pulse for an empty register list |

## Verification
On every cycle the assertions check the following. A waiting beat holds its address and index. Each accepted beat that is not the last is followed by an address four higher and a strictly higher register index. The last accepted beat is followed by a single completion cycle. An error pulse never coincides with activity. The per-beat attributes do not change within an operation. What the assertions cannot show is whether the numbers are right: the starting address for each of the four modes, the exact set of indices visited, and the written-back base value. The table-driven scenarios show these, along with wrap-around at the top of the address space, the full and single-register lists, the rejected opcode and the start that arrives while busy.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  // The register list width is fixed by the instruction layout.
  localparam int LIST_W = 16;
  localparam int IDX_W  = $clog2(LIST_W);
  localparam int CNT_W  = $clog2(LIST_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mrt_state_e;

  typedef struct packed {
    logic              pre;
    logic              up;
    logic              user;
    logic              wback;
    logic              load;
    logic [3:0]        rn;
    logic [LIST_W-1:0] list;
  } mrt_op_t;

  // Field positions follow the instruction layout; bits 27:25 must be 100.
  function automatic mrt_op_t f_decode(input logic [27:0] w);
    mrt_op_t op;
    op.pre   = w[24];
    op.up    = w[23];
    op.user  = w[22];
    op.wback = w[21];
    op.load  = w[20];
    op.rn    = w[19:16];
    op.list  = w[15:0];
    return op;
  endfunction

  function automatic logic f_is_block(input logic [27:0] w);
    return w[27:25] == 3'b100;
  endfunction

  function automatic logic [CNT_W-1:0] f_popcount(input logic [LIST_W-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < LIST_W; i++) begin
      c = c + CNT_W'(m[i]);
    end
    return c;
  endfunction

endpackage

// File: rtl/mrt_decode.sv
module mrt_decode
  import mrt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [27:0]       instr_i,
  input  logic [ADDR_W-1:0] base_i,
  output mrt_op_t           op_o,
  output logic              valid_o,
  output logic              empty_o,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] final_base_o
);

  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

  // Bytes covered by n beats.
  function automatic logic [ADDR_W-1:0] f_span(input logic [CNT_W-1:0] n);
    return ADDR_W'(n) * STEP_A;
  endfunction

  // Lowest address touched, for the four before/after x up/down modes.
  function automatic logic [ADDR_W-1:0] f_first(input logic [ADDR_W-1:0] b,
                                                input logic pre, input logic up,
                                                input logic [CNT_W-1:0] n);
    logic [ADDR_W-1:0] a;
    unique case ({pre, up})
      2'b01:   a = b;                        // increment after
      2'b11:   a = b + STEP_A;               // increment before
      2'b00:   a = b - f_span(n) + STEP_A;   // decrement after
      default: a = b - f_span(n);            // decrement before
    endcase
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] f_final(input logic [ADDR_W-1:0] b,
                                                input logic up,
                                                input logic [CNT_W-1:0] n);
    return up ? (b + f_span(n)) : (b - f_span(n));
  endfunction

  logic [CNT_W-1:0] count;

  always_comb begin
    op_o         = f_decode(instr_i);
    valid_o      = f_is_block(instr_i);
    count        = f_popcount(op_o.list);
    empty_o      = (count == '0);
    first_addr_o = f_first(base_i, op_o.pre, op_o.up, count);
    final_base_o = f_final(base_i, op_o.up, count);
  end

endmodule

// File: rtl/mrt_lowbit.sv
module mrt_lowbit
  import mrt_pkg::*;
#(
  parameter int W  = LIST_W,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [W-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  // seen[i] is high when some bit below i is set.
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < W; gi++) begin : g_chain
    assign onehot_o[gi] = mask_i[gi] & ~seen[gi];
    assign seen[gi+1]   = seen[gi] | mask_i[gi];
  end

  assign any_o = seen[W];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end

endmodule

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              empty_i,
  input  mrt_op_t           op_i,
  input  logic [ADDR_W-1:0] first_addr_i,
  input  logic [ADDR_W-1:0] final_base_i,
  input  logic [LIST_W-1:0] pick_onehot_i,
  input  logic              ready_i,
  output logic [LIST_W-1:0] rem_o,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              err_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              load_o,
  output logic              user_o,
  output logic [3:0]        rn_o,
  output logic              accept_o,
  output logic              beat_fire_o,
  output logic              last_beat_o
);

  mrt_state_e        state_q;
  logic [LIST_W-1:0] rem_q;
  logic [LIST_W-1:0] rem_next;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wb_q;
  mrt_op_t           op_q;
  logic              err_q;

  // Internal events, named for the checker.
  assign accept_o    = start_i && (state_q == ST_IDLE) && valid_i;
  assign beat_fire_o = (state_q == ST_RUN) && ready_i;
  assign rem_next    = rem_q & ~pick_onehot_i;
  assign last_beat_o = beat_fire_o && (rem_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      op_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            if (empty_i) begin
              err_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              rem_q   <= op_i.list;
              addr_q  <= first_addr_i;
              wb_q    <= final_base_i;
              op_q    <= op_i;
            end
          end
        end
        ST_RUN: begin
          if (beat_fire_o) begin
            rem_q <= rem_next;
            if (last_beat_o) begin
              state_q <= ST_DONE;
            end else begin
              addr_q <= addr_q + ADDR_W'(STEP);
            end
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign rem_o     = rem_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign req_o     = (state_q == ST_RUN);
  assign addr_o    = addr_q;
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = err_q;
  assign wb_en_o   = done_o && op_q.wback;
  assign wb_base_o = wb_q;
  assign load_o    = op_q.load;
  assign user_o    = op_q.user;
  assign rn_o      = op_q.rn;

endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
  import mrt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [27:0]       instr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              req_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              load_o,
  output logic              user_bank_o,
  output logic [3:0]        base_reg_o,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_base_o,
  output logic              err_o
);

  mrt_op_t           dec_op;
  logic              dec_valid;
  logic              dec_empty;
  logic [ADDR_W-1:0] dec_first;
  logic [ADDR_W-1:0] dec_final;
  logic [LIST_W-1:0] rem;
  logic [LIST_W-1:0] pick_onehot;
  logic              pick_any;
  logic              accept;
  logic              beat_fire;
  logic              last_beat;

  mrt_decode #(.ADDR_W(ADDR_W), .STEP(STEP)) u_decode (
    .instr_i      (instr_i),
    .base_i       (base_i),
    .op_o         (dec_op),
    .valid_o      (dec_valid),
    .empty_o      (dec_empty),
    .first_addr_o (dec_first),
    .final_base_o (dec_final)
  );

  mrt_lowbit #(.W(LIST_W), .IW(IDX_W)) u_lowbit (
    .mask_i   (rem),
    .onehot_o (pick_onehot),
    .idx_o    (reg_idx_o),
    .any_o    (pick_any)
  );

  mrt_ctrl #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .valid_i       (dec_valid),
    .empty_i       (dec_empty),
    .op_i          (dec_op),
    .first_addr_i  (dec_first),
    .final_base_i  (dec_final),
    .pick_onehot_i (pick_onehot),
    .ready_i       (ready_i),
    .rem_o         (rem),
    .busy_o        (busy_o),
    .req_o         (req_o),
    .addr_o        (addr_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .wb_en_o       (wb_en_o),
    .wb_base_o     (wb_base_o),
    .load_o        (load_o),
    .user_o        (user_bank_o),
    .rn_o          (base_reg_o),
    .accept_o      (accept),
    .beat_fire_o   (beat_fire),
    .last_beat_o   (last_beat)
  );

endmodule

// File: rtl/mrt_seq_chk.sv
module mrt_seq_chk
  import mrt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_o,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              done_o,
  input logic              err_o,
  input logic              busy_o,
  input logic              load_o,
  input logic              user_bank_o,
  input logic              accept,
  input logic              beat_fire,
  input logic              last_beat,
  input logic              pick_any
);

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ready_i |=> req_o && $stable(addr_o) && $stable(reg_idx_o)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !last_beat |=> req_o && (addr_o == $past(addr_o) + ADDR_W'(STEP))); // R4

  AST_IDX_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && !last_beat |=> reg_idx_o > $past(reg_idx_o)); // R2

  AST_REQ_HAS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> pick_any); // R2

  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && last_beat |=> done_o && !req_o); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !req_o && !done_o && !busy_o); // R7

  AST_ATTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(load_o) && $stable(user_bank_o)); // R8

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept); // R9

endmodule

bind mrt_seq mrt_seq_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_o       (req_o),
  .ready_i     (ready_i),
  .addr_o      (addr_o),
  .reg_idx_o   (reg_idx_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .busy_o      (busy_o),
  .load_o      (load_o),
  .user_bank_o (user_bank_o),
  .accept      (accept),
  .beat_fire   (beat_fire),
  .last_beat   (last_beat),
  .pick_any    (pick_any)
);

// File: tb/mrt_seq_test.sv
module mrt_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;
  localparam int NVEC       = 8;

  // {p,u,s,w,l}[120:116] rn[115:112] list[111:96] base[95:64] first[63:32] wb[31:0]
  localparam logic [120:0] TBL [NVEC] = '{
    {5'b01011, 4'd1,  16'h0007, 32'h0000_1000, 32'h0000_1000, 32'h0000_100C},
    {5'b11000, 4'd13, 16'h8001, 32'h0000_0200, 32'h0000_0204, 32'h0000_0208},
    {5'b00111, 4'd2,  16'h00F0, 32'h0000_0400, 32'h0000_03F4, 32'h0000_03F0},
    {5'b10010, 4'd13, 16'h4000, 32'h0000_0100, 32'h0000_00FC, 32'h0000_00FC},
    {5'b10101, 4'd0,  16'hFFFF, 32'h0000_2000, 32'h0000_1FC0, 32'h0000_1FC0},
    {5'b01010, 4'd3,  16'h0003, 32'hFFFF_FFF8, 32'hFFFF_FFF8, 32'h0000_0000},
    {5'b11110, 4'd7,  16'hAAAA, 32'h0000_0000, 32'h0000_0004, 32'h0000_0020},
    {5'b00011, 4'd4,  16'h0001, 32'h0000_0010, 32'h0000_0010, 32'h0000_000C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [27:0] instr_i = '0;
  logic [31:0] base_i = '0;
  logic        ready_i = 1'b0;
  logic        busy_o, req_o, load_o, user_bank_o, done_o, wb_en_o, err_o;
  logic [31:0] addr_o, wb_base_o;
  logic [3:0]  reg_idx_o, base_reg_o;

  int n_checks = 0;
  int n_fail   = 0;

  mrt_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .base_i(base_i),
    .busy_o(busy_o), .req_o(req_o), .ready_i(ready_i), .addr_o(addr_o),
    .reg_idx_o(reg_idx_o), .load_o(load_o), .user_bank_o(user_bank_o),
    .base_reg_o(base_reg_o), .done_o(done_o), .wb_en_o(wb_en_o),
    .wb_base_o(wb_base_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic logic [27:0] mk_instr(input logic [4:0] f, input logic [3:0] rn,
                                           input logic [15:0] list);
    return {3'b100, f, rn, list};
  endfunction

  // Starts an operation, serves every beat with a varying wait, checks completion.
  task automatic run_op(input logic [120:0] v, input int vi);
    logic [4:0]  f;
    logic [3:0]  rn;
    logic [15:0] list;
    logic [31:0] exp_addr;
    int          beat;
    f    = v[120:116];
    rn   = v[115:112];
    list = v[111:96];
    @(negedge clk);
    start_i = 1'b1;
    instr_i = mk_instr(f, rn, list);
    base_i  = v[95:64];
    @(negedge clk);
    start_i  = 1'b0;
    instr_i  = '0;
    base_i   = 32'hDEAD_BEEF;
    exp_addr = v[63:32];
    beat     = 0;
    for (int j = 0; j < 16; j++) begin
      if (list[j]) begin
        chk(req_o === 1'b1, "R2 request per set bit", 32'(req_o), 32'd1);
        chk(reg_idx_o === 4'(j), "R2 ascending index", 32'(reg_idx_o), 32'(j));
        if (beat == 0)
          chk(addr_o === exp_addr, "R3 first address", addr_o, exp_addr);
        else
          chk(addr_o === exp_addr, "R4 address step", addr_o, exp_addr);
        chk(load_o === f[0] && user_bank_o === f[2] && base_reg_o === rn,
            "R8 attributes", {load_o, user_bank_o, base_reg_o}, {f[0], f[2], rn});
        for (int w = 0; w < (vi + beat) % 3; w++) begin
          @(negedge clk);
          chk(req_o === 1'b1 && addr_o === exp_addr && reg_idx_o === 4'(j),
              "R5 hold while waiting", addr_o, exp_addr);
        end
        ready_i = 1'b1;
        @(negedge clk);
        ready_i  = 1'b0;
        exp_addr = exp_addr + 32'd4;
        beat++;
      end
    end
    chk(done_o === 1'b1 && req_o === 1'b0, "R6 done after last beat",
        32'({done_o, req_o}), 32'b10);
    chk(wb_base_o === v[31:0], "R6 written-back base", wb_base_o, v[31:0]);
    chk(wb_en_o === f[1], "R6 write-back enable", 32'(wb_en_o), 32'(f[1]));
    @(negedge clk);
    chk(done_o === 1'b0 && busy_o === 1'b0, "R6 single done pulse",
        32'({done_o, busy_o}), 32'd0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk({busy_o, req_o, done_o, err_o, wb_en_o} === 5'b0, "R10 outputs in reset",
        32'({busy_o, req_o, done_o, err_o, wb_en_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, req_o, done_o, err_o, wb_en_o} === 5'b0, "R10 outputs after reset",
        32'({busy_o, req_o, done_o, err_o, wb_en_o}), 32'd0);

    // R1, R2, R3, R4, R5, R6, R8: table of operations
    for (int i = 0; i < NVEC; i++) run_op(TBL[i], i);

    // R7: empty register list
    @(negedge clk);
    start_i = 1'b1;
    instr_i = mk_instr(5'b01011, 4'd5, 16'h0000);
    base_i  = 32'h300;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o === 1'b1 && req_o === 1'b0, "R7 error pulse", 32'({err_o, req_o}), 32'b10);
    @(negedge clk);
    chk({err_o, req_o, busy_o, done_o} === 4'b0, "R7 stays idle",
        32'({err_o, req_o, busy_o, done_o}), 32'd0);

    // R1: wrong opcode bits 27:25 ignored
    @(negedge clk);
    start_i = 1'b1;
    instr_i = {3'b000, 5'b01011, 4'd1, 16'h0001};
    @(negedge clk);
    start_i = 1'b0;
    chk({err_o, req_o, busy_o} === 3'b0, "R1 non-block opcode ignored",
        32'({err_o, req_o, busy_o}), 32'd0);

    // R9: start while busy ignored
    @(negedge clk);
    start_i = 1'b1;
    instr_i = mk_instr(5'b01000, 4'd6, 16'h0003);
    base_i  = 32'h500;
    @(negedge clk);
    instr_i = mk_instr(5'b11011, 4'd9, 16'hF000);
    base_i  = 32'h9000;
    @(negedge clk);
    start_i = 1'b0;
    chk(addr_o === 32'h500 && reg_idx_o === 4'd0 && base_reg_o === 4'd6,
        "R9 running beat unchanged", addr_o, 32'h500);
    ready_i = 1'b1;
    @(negedge clk);
    chk(addr_o === 32'h504 && reg_idx_o === 4'd1, "R9 second beat of first op",
        addr_o, 32'h504);
    @(negedge clk);
    ready_i = 1'b0;
    chk(done_o === 1'b1 && wb_base_o === 32'h508, "R9 first op completes",
        wb_base_o, 32'h508);
    @(negedge clk);
    chk(busy_o === 1'b0 && req_o === 1'b0, "R9 no second op started",
        32'({busy_o, req_o}), 32'd0);

    summary();
  end

endmodule